// File: doc/BRIEF.md
# Data-Processing ALU Stage with Condition Flags

This block is one pipeline stage of a 32-bit integer datapath. It takes a 4-bit operation code, a first operand, an already shifted second operand, the carry produced by the shifter, and the current condition flags. From these it computes a result, decides whether the result is written back, and produces the next N, Z, C and V flags. The sixteen operations are bitwise logic, moves, add and subtract in both operand orders with optional carry, and four compare/test forms that only touch the flags.

Two control bits steer the flag path. The set-flags bit asks for a flag update. The destination-is-PC bit marks a write to the program counter. With both set, the top four result bits reload the whole flag word, and the stage raises a status-load request. This also happens for compare and test forms. With set-flags clear, the flags pass through unchanged. Writing only the program-counter field in that case is left to the register file.

Operations enter on a valid/ready input and leave through a one-entry registered output with valid/ready. A transfer happens on any clock edge where both valid and ready are high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `dpa_stage`

## Requirements
- R1: Operation codes are AND=0x0, EOR=0x1, SUB=0x2, RSB=0x3, ADD=0x4, ADC=0x5, SBC=0x6, RSC=0x7, TST=0x8, TEQ=0x9, CMP=0xA, CMN=0xB, ORR=0xC, MOV=0xD, BIC=0xE, MVN=0xF. The logic results are: AND/TST op1&op2, EOR/TEQ op1^op2, ORR op1|op2, MOV op2, BIC op1&~op2, MVN ~op2.
- R2: ADD/CMN give op1+op2 and ADC gives op1+op2+C. SUB/CMP give op1−op2, SBC gives op1−op2−(1−C), RSB gives op2−op1, and RSC gives op2−op1−(1−C). All are taken modulo 2^32.
- R3: `out_wr_en` is 0 for codes 0x8–0xB and 1 for every other code, whatever the PC and set-flags bits are.
- R4: The flag word is {N,Z,C,V} in bits [3:2:1:0]. With set-flags 1 and destination not the PC, N equals result bit 31 and Z is 1 exactly when all 32 result bits are 0.
- R5: In that same case, the logic codes (0,1,8,9,C,D,E,F) take C from the shifter carry input and leave V at its input value.
- R6: In that same case, the arithmetic codes set C to the carry out of bit 31. For subtraction this is NOT borrow, so C=1 when no borrow occurs. V is set to signed overflow.
- R7: With set-flags 0, `out_flags` equals the input flags and `out_status_load` is 0.
- R8: With set-flags 1 and destination the PC, `out_status_load` is 1 and `out_flags` equals result bits [31:28]. This holds for every code, including the compare and test codes.
- R9: `in_ready` = !out_valid || out_ready. While out_valid=1 and out_ready=0, out_valid and all output fields hold their values on the next cycle.
- R10: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Stage can accept an operation |
| in_op | input | 4 | Operation code (R1) |
| in_op1 | input | 32 | First operand |
| in_op2 | input | 32 | Shifted second operand |
| in_shc | input | 1 | Shifter carry-out |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| in_set_flags | input | 1 | Request a flag update |
| in_dest_pc | input | 1 | Destination is the program counter |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 32 | Operation result |
| out_wr_en | output | 1 | Write the destination register |
| out_flags | output | 4 | Next flags {N,Z,C,V} |
| out_status_load | output | 1 | Overwrite the status word from the result |

## Verification
The assertions assume the input fields are known whenever `in_valid` is high. They also assume the consumer does not depend on output fields while `out_valid` is low. The flag checks are tied to the cycle after an accepted transfer, so they assume inputs change only between edges.

The bench drives inputs on the falling edge and holds them for a full cycle. It keeps `in_valid` low except during a deliberate transfer. It varies the hold time on `out_ready`, so the stability check sees both short and long stalls.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dpa_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
  localparam int FLG_W = 4;

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_logical(input logic [3:0] op);
    logic r;
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: r = 1'b1;
      default:                        r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dpa_logic.sv
module dpa_logic
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dpa_addsub.sv
module dpa_addsub
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] x, y;
  logic         ci;

  // Subtraction is x + ~y + 1; the carry-in slot absorbs the old C for the
  // carrying forms, which makes C an inverted borrow.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    case (op)
      OP_ADC:         ci = c_in;
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
      OP_SBC:         begin y = ~b; ci = c_in; end
      OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
      OP_RSC:         begin x = b; y = ~a; ci = c_in; end
      default:        ;
    endcase
  end

  always_comb begin
    {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dpa_flags.sv
module dpa_flags
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]       op,
  input  logic [W-1:0]     res,
  input  logic             cout,
  input  logic             ovf,
  input  logic             shc,
  input  logic [FLG_W-1:0] flags_in,
  input  logic             set_flags,
  input  logic             dest_pc,
  output logic             wr_en,
  output logic [FLG_W-1:0] flags_out,
  output logic             status_load
);
  logic is_log;

  always_comb begin
    is_log      = op_is_logical(op);
    wr_en       = !op_is_compare(op);
    status_load = 1'b0;
    flags_out   = flags_in;
    if (set_flags && dest_pc) begin
      status_load = 1'b1;
      flags_out   = res[W-1 -: FLG_W];
    end else if (set_flags) begin
      flags_out[FLG_N] = res[W-1];
      flags_out[FLG_Z] = ~|res;
      flags_out[FLG_C] = is_log ? shc : cout;
      flags_out[FLG_V] = is_log ? flags_in[FLG_V] : ovf;
    end
  end
endmodule

// File: rtl/dpa_stage.sv
module dpa_stage
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [31:0]  in_op1,
  input  logic [31:0]  in_op2,
  input  logic         in_shc,
  input  logic [3:0]   in_flags,
  input  logic         in_set_flags,
  input  logic         in_dest_pc,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [31:0]  out_result,
  output logic         out_wr_en,
  output logic [3:0]   out_flags,
  output logic         out_status_load
);
  logic [W-1:0] log_res, arith_res, res_c;
  logic         cout_c, ovf_c, wr_c, ld_c;
  logic [3:0]   flg_c;
  logic         accept;

  dpa_logic #(.W(W)) u_logic (
    .op(in_op), .a(in_op1), .b(in_op2), .res(log_res)
  );

  dpa_addsub #(.W(W)) u_addsub (
    .op(in_op), .a(in_op1), .b(in_op2), .c_in(in_flags[FLG_C]),
    .sum(arith_res), .cout(cout_c), .ovf(ovf_c)
  );

  assign res_c = op_is_logical(in_op) ? log_res : arith_res;

  dpa_flags #(.W(W)) u_flags (
    .op(in_op), .res(res_c), .cout(cout_c), .ovf(ovf_c), .shc(in_shc),
    .flags_in(in_flags), .set_flags(in_set_flags), .dest_pc(in_dest_pc),
    .wr_en(wr_c), .flags_out(flg_c), .status_load(ld_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_wr_en       <= 1'b0;
      out_flags       <= '0;
      out_status_load <= 1'b0;
    end else begin
      if (accept) begin
        out_valid       <= 1'b1;
        out_result      <= res_c;
        out_wr_en       <= wr_c;
        out_flags       <= flg_c;
        out_status_load <= ld_c;
      end else if (out_ready) begin
        out_valid       <= 1'b0;
      end
    end
  end

  // R9: a stalled result stays put
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_wr_en) && $stable(out_status_load));

  // R3: compare/test never writes back
  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op[3:2] == 2'b10 |=> out_valid && !out_wr_en);

  // R7: flags pass through when not requested
  p_flags_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_set_flags |=> out_flags == $past(in_flags) && !out_status_load);

  // R4: N and Z follow the stored result
  p_nz_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_set_flags && !in_dest_pc |=>
      out_flags[FLG_Z] == (out_result == '0) && out_flags[FLG_N] == out_result[31]);

  // R8: status reload from result top bits
  p_status_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_set_flags && in_dest_pc |=>
      out_status_load && out_flags == out_result[31:28]);

  // R5: logic ops keep V and take C from the shifter
  p_logic_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_set_flags && !in_dest_pc && op_is_logical(in_op) |=>
      out_flags[FLG_V] == $past(in_flags[FLG_V]) && out_flags[FLG_C] == $past(in_shc));
endmodule

// File: tb/dpa_stage_tb.sv
`timescale 1ns/1ps
module dpa_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_op1 = '0, in_op2 = '0;
  logic        in_shc = 1'b0;
  logic [3:0]  in_flags = '0;
  logic        in_set_flags = 1'b0, in_dest_pc = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_wr_en, out_status_load;
  logic [3:0]  out_flags;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpa_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_op1(in_op1), .in_op2(in_op2), .in_shc(in_shc),
    .in_flags(in_flags), .in_set_flags(in_set_flags), .in_dest_pc(in_dest_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags), .out_status_load(out_status_load)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  task automatic ref_model(input logic [3:0] op, input logic [31:0] a, b,
                           input logic shc, input logic [3:0] f,
                           input logic s, pc,
                           output logic [31:0] res, output logic we,
                           output logic [3:0] nf, output logic ld);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint cf = longint'(f[1]);
    longint u, sg;
    logic lg, c, v;
    lg = 1'b0; c = 1'b0; v = 1'b0; u = 0; sg = 0;
    case (op)
      4'h0, 4'h8: begin lg = 1; res = a & b; end
      4'h1, 4'h9: begin lg = 1; res = a ^ b; end
      4'hC: begin lg = 1; res = a | b; end
      4'hD: begin lg = 1; res = b; end
      4'hE: begin lg = 1; res = a & ~b; end
      4'hF: begin lg = 1; res = ~b; end
      4'h4, 4'hB: begin u = ua + ub; sg = sa + sb; end
      4'h5: begin u = ua + ub + cf; sg = sa + sb + cf; end
      4'h2, 4'hA: begin u = ua - ub; sg = sa - sb; end
      4'h6: begin u = ua - ub - (1 - cf); sg = sa - sb - (1 - cf); end
      4'h3: begin u = ub - ua; sg = sb - sa; end
      default: begin u = ub - ua - (1 - cf); sg = sb - sa - (1 - cf); end
    endcase
    if (!lg) begin
      res = u[31:0];
      if (op == 4'h4 || op == 4'h5 || op == 4'hB) c = (u > 64'sd4294967295);
      else c = (u >= 0);
      v = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
    end
    we = !(op >= 4'h8 && op <= 4'hB);
    ld = s && pc;
    if (!s) nf = f;
    else if (pc) nf = res[31:28];
    else nf = {res[31], res == 32'd0, lg ? shc : c, lg ? f[0] : v};
  endtask

  task automatic run_txn(input logic [3:0] op, input logic [31:0] a, b,
                         input logic shc, input logic [3:0] f,
                         input logic s, pc, input int hold);
    logic [31:0] er; logic ew, el; logic [3:0] ef;
    ref_model(op, a, b, shc, f, s, pc, er, ew, ef, el);
    @(negedge clk);
    in_valid = 1; in_op = op; in_op1 = a; in_op2 = b; in_shc = shc;
    in_flags = f; in_set_flags = s; in_dest_pc = pc; out_ready = 0;
    chk("R9 in_ready empty", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 0;
    chk("R1/R2 result", out_result, er);
    chk("R3 wr_en", 32'(out_wr_en), 32'(ew));
    chk("R4/R5/R6/R7/R8 flags", 32'(out_flags), 32'(ef));
    chk("R8 status_load", 32'(out_status_load), 32'(el));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9 stall valid", 32'(out_valid), 32'd1);
      chk("R9 stall ready", 32'(in_ready), 32'd0);
      chk("R9 stall data", out_result, er);
    end
    out_ready = 1;
    #0.1 chk("R9 ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    out_ready = 0;
    chk("R9 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset in_ready", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1;
    // Directed corners
    run_txn(4'h4, 32'h7FFF_FFFF, 32'd1, 0, 4'h0, 1, 0, 0);       // R6 V set
    run_txn(4'h4, 32'hFFFF_FFFF, 32'd1, 0, 4'h0, 1, 0, 1);       // R6 C, R4 Z
    run_txn(4'h2, 32'd5, 32'd5, 0, 4'h0, 1, 0, 0);               // R6 no borrow C=1
    run_txn(4'h2, 32'd0, 32'd1, 0, 4'hF, 1, 0, 0);               // R6 borrow C=0
    run_txn(4'h6, 32'd10, 32'd3, 0, 4'h0, 1, 0, 0);              // R2 SBC C=0 -> 6
    run_txn(4'h7, 32'd3, 32'd10, 0, 4'h2, 1, 0, 0);              // R2 RSC C=1 -> 7
    run_txn(4'h3, 32'd1, 32'd0, 0, 4'h0, 1, 0, 0);               // R2 RSB
    run_txn(4'h5, 32'd1, 32'd1, 0, 4'h2, 1, 0, 0);               // R2 ADC
    run_txn(4'h8, 32'hF0F0_0000, 32'h0F0F_0000, 1, 4'h1, 1, 0, 2); // R3 R5 TST zero
    run_txn(4'hA, 32'hA000_0000, 32'd0, 0, 4'h0, 1, 1, 0);       // R8 CMP to PC
    run_txn(4'hD, 32'd0, 32'h5000_1234, 0, 4'hA, 0, 1, 0);       // R7 MOV PC no S
    run_txn(4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 4'h3, 1, 0, 0); // R1 BIC
    run_txn(4'hF, 32'd0, 32'd0, 1, 4'h0, 1, 0, 3);               // R1 MVN, R5
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [3:0] op;
      op = 4'($urandom());
      a  = $urandom(); b = $urandom();
      if (($urandom() % 8) == 0) b = a;
      if (($urandom() % 8) == 1) a = 32'h8000_0000;
      run_txn(op, a, b, 1'($urandom()), 4'($urandom()),
              1'($urandom()), (($urandom() % 4) == 0), int'($urandom() % 3));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule